// File: doc/BRIEF.md
# Register-Exchange Survivor Path Store

This block is the survivor store of a Viterbi decoder built on the register-exchange principle. For every trellis state it keeps one shift register that holds the complete decided bit history of the best path ending in that state. Each accepted trellis step rewrites every register at once. The new content of a register is a copy of the register of the predecessor that the add-compare-select stage chose for that state, shifted by one place, with the label of the chosen branch written in as the newest bit.

The block reads the decoded bit straight from the oldest end of the register that belongs to the best state, which is supplied from outside. No traceback pass is needed, so a decoded bit is ready in the cycle after each step once the registers hold a full history. The trellis follows a right-shift convention. State `s` is reached from predecessor `((s << 1) mod N) | d`, where `d` is the state's decision bit. The branch label of every branch into `s` is the most significant bit of `s`.

Top module: `rx_survivor_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every survivor register is cleared and the fill count is cleared. After reset, `bit_valid` is 0 and `bit_out` is 0 for every value of `best_state`.
- R2: At an edge where `dec_valid` is 0, no survivor register and no fill count changes.
- R3: On an accepted step (`dec_valid` = 1), bit 0 (the newest position) of the register for state `s` becomes bit V-1 of `s`.
- R4: On an accepted step, bits S-1..1 of the register for state `s` take bits S-2..0 of the old register of predecessor `((s << 1) mod N) | dec_vec[s]`. Decision 0 picks the even predecessor and decision 1 picks the odd one.
- R5: `bit_out` is bit S-1 (the oldest position) of the register selected by `best_state`. It follows `best_state` combinationally in the same cycle.
- R6: `bit_valid` becomes 1 after exactly S accepted steps since reset. It then stays 1 until the next reset.
- R7: When the decisions along a path follow an encoder whose state is `{u, prev[V-1:1]}` for input bit `u`, and `best_state` names the current state of that path, then after accepted step k (counting from 0, with k ≥ S-1) `bit_out` equals the input bit of step k-S+1.
- R8: A reset asserted in the middle of operation clears all survivors and drops `bit_valid` at the next edge. This holds even while `dec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Marks an accepted trellis step |
| dec_vec | input | N (4) | One decision bit per state; bit s belongs to state s |
| best_state | input | V (2) | State whose survivor supplies the output |
| bit_out | output | 1 | Oldest bit of the selected survivor |
| bit_valid | output | 1 | Survivors hold S steps of history |

## Verification
The bench aims at the fill boundary. It checks that `bit_valid` stays low on step S-1 and rises on step S, and that idle cycles mixed into the fill do not count as steps. A counter that is off by one or that counts idle cycles fails that check. Random decision vectors against a bench model reach every predecessor choice for every state, so a swapped mux leg, a wrong predecessor index or a wrong branch label shows up as a wrong oldest bit in some state. An encoder-driven path test confirms that the decoded stream is the input delayed by exactly S-1 steps, which would expose a shift in the wrong direction or a read from the wrong end. A mid-run reset with `dec_valid` held high checks that reset has priority over an update.

// File: rtl/rx_survivor_pkg.sv
// Shared trellis helpers for the register-exchange survivor store.
// Assumes a right-shift trellis: state s = {input, prev[V-1:1]}.
package rx_survivor_pkg;

    // Predecessor of state s when its decision bit is d.
    function automatic int unsigned rx_pred(int unsigned s, int unsigned d, int unsigned n_states);
        return ((s << 1) & (n_states - 1)) | (d & 1);
    endfunction

    // Branch label of every branch entering state s (its top bit).
    function automatic int unsigned rx_label(int unsigned s, int unsigned v_bits);
        return (s >> (v_bits - 1)) & 1;
    endfunction

endpackage

// File: rtl/rxs_row.sv
// One survivor register with its exchange multiplexer.
// On enable it loads the chosen predecessor's history shifted up by one
// place, with LABEL as the newest bit. Assumes S >= 2.
module rxs_row #(
    parameter int unsigned S     = 15,
    parameter bit          LABEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dec,
    input  logic [S-1:0] from_even,
    input  logic [S-1:0] from_odd,
    output logic [S-1:0] q
);
    logic [S-1:0] chosen;

    // Pick the predecessor history named by the decision bit.
    always_comb begin
        chosen = dec ? from_odd : from_even;
    end

    // Clear on reset, otherwise shift in the branch label on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= {chosen[S-2:0], LABEL};
        end
    end
endmodule

// File: rtl/rxs_fill.sv
// Counts accepted steps up to S and flags when the survivors are full.
// Saturates at S; cleared by synchronous reset.
module rxs_fill #(
    parameter int unsigned S = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic full
);
    localparam int unsigned CW = $clog2(S + 1);

    logic [CW-1:0] cnt;

    // Full once the count reaches S.
    always_comb begin
        full = (cnt == CW'(S));
    end

    // Count accepted steps, holding at S.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en && !full) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxs_pick.sv
// Output selector: oldest bit of the survivor chosen by an index.
// Purely combinational; the index is assumed to be in range.
module rxs_pick #(
    parameter int unsigned V = 2,
    parameter int unsigned S = 15,
    localparam int unsigned N = 1 << V
) (
    input  logic [N-1:0][S-1:0] surv,
    input  logic [V-1:0]        sel,
    output logic                bit_o
);
    logic [N-1:0] oldest;

    // Gather the oldest bit of every survivor, then index it.
    always_comb begin
        for (int s = 0; s < N; s++) begin
            oldest[s] = surv[s][S-1];
        end
        bit_o = oldest[sel];
    end
endmodule

// File: rtl/rx_survivor_unit.sv
// Register-exchange survivor store. Holds one S-bit history per trellis
// state, rewrites all of them on every accepted step from the decisions,
// and returns the oldest bit of the externally chosen best state.
// Assumes decisions arrive one trellis step per dec_valid pulse.
module rx_survivor_unit #(
    parameter int unsigned V = 2,
    parameter int unsigned S = 15,
    localparam int unsigned N = 1 << V
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_valid,
    input  logic [N-1:0] dec_vec,
    input  logic [V-1:0] best_state,
    output logic         bit_out,
    output logic         bit_valid
);
    import rx_survivor_pkg::*;

    logic [N-1:0][S-1:0] surv_q;

    // One exchange row per state, wired to its two possible predecessors.
    for (genvar gs = 0; gs < N; gs++) begin : g_row
        localparam int unsigned PE  = rx_pred(gs, 0, N);
        localparam int unsigned PO  = rx_pred(gs, 1, N);
        localparam bit          LAB = bit'(rx_label(gs, V));

        rxs_row #(.S(S), .LABEL(LAB)) row_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (dec_valid),
            .dec       (dec_vec[gs]),
            .from_even (surv_q[PE]),
            .from_odd  (surv_q[PO]),
            .q         (surv_q[gs])
        );
    end

    rxs_fill #(.S(S)) fill_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dec_valid),
        .full  (bit_valid)
    );

    rxs_pick #(.V(V), .S(S)) pick_i (
        .surv  (surv_q),
        .sel   (best_state),
        .bit_o (bit_out)
    );
endmodule

// File: rtl/rx_survivor_unit_chk.sv
// Temporal checks on the survivor store, attached by bind.
module rx_survivor_unit_chk #(
    parameter int unsigned V = 2,
    parameter int unsigned S = 15,
    localparam int unsigned N = 1 << V
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dec_valid,
    input logic [N-1:0][S-1:0] surv,
    input logic                bit_valid
);
    logic [N-1:0] newest;
    logic [N-1:0] want_lab;

    // Collect the newest bit of each survivor and the label it should carry.
    always_comb begin
        for (int s = 0; s < N; s++) begin
            newest[s]   = surv[s][0];
            want_lab[s] = s[V-1];
        end
    end

    // R2: no step, no change to any survivor.
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> $stable(surv));

    // R3: after a step every newest bit is its state's label.
    p_label_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (newest == want_lab));

    // R6: once valid, stays valid.
    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> bit_valid);

    // R6: valid only rises on an accepted step.
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> $past(dec_valid));

    // R8: reset clears valid at the next edge.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> !bit_valid);
endmodule

bind rx_survivor_unit rx_survivor_unit_chk #(.V(V), .S(S)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .surv      (surv_q),
    .bit_valid (bit_valid)
);

// File: tb/rx_survivor_unit_tb_top.sv
// Directed bench for the register-exchange survivor store.
module rx_survivor_unit_tb_top;
    localparam int unsigned V = 2;
    localparam int unsigned S = 15;
    localparam int unsigned N = 1 << V;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dec_valid = 1'b0;
    logic [N-1:0] dec_vec = '0;
    logic [V-1:0] best_state = '0;
    logic         bit_out;
    logic         bit_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [S-1:0] model [N];

    rx_survivor_unit #(.V(V), .S(S)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .dec_vec    (dec_vec),
        .best_state (best_state),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Model update from R3/R4.
    task automatic model_step(input logic [N-1:0] vec);
        logic [S-1:0] nxt [N];
        for (int s = 0; s < N; s++) begin
            int unsigned p;
            p = ((s << 1) & (N - 1)) | vec[s];
            nxt[s] = {model[p][S-2:0], 1'(s >> (V - 1))};
        end
        for (int s = 0; s < N; s++) model[s] = nxt[s];
    endtask

    // Drive one cycle; update the model if accepted.
    task automatic step(input logic dv, input logic [N-1:0] vec);
        @(negedge clk);
        dec_valid = dv;
        dec_vec   = vec;
        @(posedge clk);
        #1;
        dec_valid = 1'b0;
        if (dv && rst_n) model_step(vec);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int s = 0; s < N; s++) model[s] = '0;
    endtask

    // Sweep best_state and compare every oldest bit against the model.
    task automatic cmp_all(input string req);
        @(negedge clk);
        for (int b = 0; b < N; b++) begin
            best_state = V'(b);
            #1;
            chk(req, bit_out, model[b][S-1]);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 valid after reset", bit_valid, 1'b0);
        cmp_all("R1 survivors cleared");
    endtask

    // R6/R2: fill boundary with idle cycles mixed in.
    task automatic t_fill();
        do_reset();
        for (int k = 0; k < S - 1; k++) begin
            step(1'b1, N'(k * 5 + 3));
            if (k == 3) begin
                step(1'b0, '1);
                step(1'b0, '0);
            end
        end
        @(negedge clk);
        chk("R6 valid low at S-1 steps", bit_valid, 1'b0);
        step(1'b0, '1);
        @(negedge clk);
        chk("R2 idle does not count", bit_valid, 1'b0);
        step(1'b1, '0);
        @(negedge clk);
        chk("R6 valid high at S steps", bit_valid, 1'b1);
        step(1'b1, '1);
        @(negedge clk);
        chk("R6 valid stays high", bit_valid, 1'b1);
    endtask

    // R3/R4/R5/R2: random decisions against the model, idle holds.
    task automatic t_random();
        do_reset();
        for (int k = 0; k < 40; k++) begin
            step(1'b1, N'($urandom));
            if (k >= 10 && (k % 6) == 0) cmp_all("R4 exchange vs model");
        end
        cmp_all("R3 labels propagated");
        step(1'b0, N'($urandom));
        step(1'b0, N'($urandom));
        cmp_all("R2 survivors held while idle");
        step(1'b1, '0);
        cmp_all("R5 selection all zero decisions");
        for (int k = 0; k < S; k++) step(1'b1, '1);
        cmp_all("R5 selection all one decisions");
    endtask

    // R7: decode an encoder path; other states get random decisions.
    task automatic t_path();
        logic [V-1:0] st;
        logic [63:0]  ubits;
        do_reset();
        st = '0;
        ubits = {$urandom, $urandom};
        for (int k = 0; k < 50; k++) begin
            logic [V-1:0] nx;
            logic [N-1:0] vec;
            nx  = {ubits[k], st[V-1:1]};
            vec = N'($urandom);
            vec[nx] = st[0];
            step(1'b1, vec);
            st = nx;
            if (k >= S - 1) begin
                @(negedge clk);
                best_state = st;
                #1;
                chk("R7 decoded bit", bit_out, ubits[k - S + 1]);
            end
        end
    endtask

    // R8: reset mid-run with dec_valid high.
    task automatic t_midreset();
        for (int k = 0; k < S + 2; k++) step(1'b1, N'($urandom));
        @(negedge clk);
        chk("R8 valid before reset", bit_valid, 1'b1);
        rst_n = 1'b0;
        dec_valid = 1'b1;
        dec_vec = '1;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        dec_valid = 1'b0;
        for (int s = 0; s < N; s++) model[s] = '0;
        @(negedge clk);
        chk("R8 valid cleared", bit_valid, 1'b0);
        cmp_all("R8 survivors cleared");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_random();
        t_path();
        t_midreset();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end
endmodule